// File: doc/BRIEF.md
# Cipher Key Slot Table Loader

This block keeps a small table of cipher key records next to a cipher core. Each record is 64 bytes and holds a 256-bit key, a 128-bit starting IV and a 128-bit running IV. Records are filled from a word-addressed on-chip RAM by one packed 32-bit command. The command names the table, the target slot and a 16-byte-aligned byte address in RAM. The block then reads sixteen consecutive words on its own RAM read port and writes them into the slot.

Two configuration writes steer what the core sees. One picks the active slot. The other sets the key length in bits. The selected record appears on registered read ports: key bytes past the configured length are forced to zero, and a slot index past the table gives all zeros. While the IV-update mode is on, the core may overwrite the running IV of the active slot. The starting IV is changed only by a load. Slot 0 comes out of reset holding a boot-time key, and a normal load can overwrite or clear it.

Top module: `keyslot_loader`

## Requirements
- R1: After reset the slot-0 key equals the BOOT_KEY parameter, every other stored field is zero, the active slot is 0, the key length is 128, and busy and the RAM read enable are low.
- R2: A command is accepted when bits [31:26] equal 0x15, bits [25:24] equal 3, bits [23:20] of the table ID field [23:17] equal 0001, the slot number in bits [19:17] is below NUM_SLOTS, and bits [3:0] of the byte address in [16:0] are zero.
- R3: A command that fails any condition of R2 and arrives while idle makes cmd_rej high for exactly the next cycle. It starts no RAM read and leaves busy low.
- R4: A load reads words at (address>>2)+0 to +15. Word w is stored at bit 32*w of the record: words 0-7 form the key, words 8-11 the starting IV and words 12-15 the running IV.
- R5: busy rises in the cycle after an accepted command and stays high for 17 cycles. ram_rd_en is high for 16 of those cycles, and ram_rd_addr steps by one each cycle. RAM data is expected one cycle after the address.
- R6: A command presented while busy is ignored. It neither rejects nor changes any slot.
- R7: A slot write (cfg_sel=0) takes the active slot from bits [24:20]. An index of NUM_SLOTS or more drives all three read ports to zero.
- R8: A length write (cfg_sel=1) takes a 9-bit value from bits [24:16]. A value below 128 or above 256 is ignored and the old length is kept.
- R9: Key byte i (key_out[8i+7:8i]) reads as zero when i is at least the key length divided by 8.
- R10: With ivu_mode high and the block idle, iv_upd_we writes iv_upd_data into the running IV of the active slot. With ivu_mode low it has no effect, and the starting IV never changes from it.
- R11: A load into slot 0 replaces the boot-time key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_word | input | 32 | Packed load command |
| cmd_rej | output | 1 | One-cycle pulse for a refused command |
| busy | output | 1 | Load in progress |
| ram_rd_en | output | 1 | RAM read enable |
| ram_rd_addr | output | 15 | RAM word address |
| ram_rd_data | input | 32 | RAM read data, one cycle after address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: active slot, 1: key length |
| cfg_wdata | input | 32 | Configuration write data |
| ivu_mode | input | 1 | IV-update mode enable |
| iv_upd_we | input | 1 | Core write of the running IV |
| iv_upd_data | input | 128 | New running IV |
| key_out | output | 256 | Masked key of the active slot |
| iv_orig_out | output | 128 | Starting IV of the active slot |
| iv_upd_out | output | 128 | Running IV of the active slot |

## Verification
The assertions assume that cmd_valid only marks a command on a cycle where the command word is stable, and that the RAM returns data for each address exactly one cycle after it is presented. The bench RAM model keeps to that latency. Its contents are a computed function of the address, so every expected record follows from the command address alone. Commands and configuration writes are driven on the falling edge and held for one full cycle. The only command sent during a load is the one that checks R6.

// File: rtl/keyslot_pkg.sv
package keyslot_pkg;
  // Packed load command layout; the positions are decoded by the command source.
  localparam int CMD_W          = 32;
  localparam int OPC_LSB        = 26;
  localparam int OPC_W          = 6;
  localparam logic [OPC_W-1:0] SET_TABLE_OPC = 6'h15;
  localparam int TSEL_LSB       = 24;
  localparam int TSEL_W         = 2;
  localparam logic [TSEL_W-1:0] CRYPTO_TSEL = 2'd3;
  localparam int TID_LSB        = 17;
  localparam int TID_W          = 7;
  localparam int TID_SLOT_W     = 3;
  localparam logic [TID_W-TID_SLOT_W-1:0] KEY_TID_TAG = 4'b0001;
  localparam int ADDR_W         = 17;
  localparam int RAM_AW         = ADDR_W - 2;
  localparam int ALIGN_BITS     = 4;

  // Configuration fields
  localparam int SLOT_FIELD_LSB = 20;
  localparam int SLOT_FIELD_W   = 5;
  localparam int LEN_FIELD_LSB  = 16;
  localparam int LEN_FIELD_W    = 9;

  typedef struct packed {
    logic                  ok;
    logic [TID_SLOT_W-1:0] slot;
    logic [ADDR_W-1:0]     addr;
  } load_req_t;

  typedef enum logic {
    CFG_SLOT = 1'b0,
    CFG_LEN  = 1'b1
  } cfg_target_e;
endpackage

// File: rtl/keyslot_cmd_decode.sv
module keyslot_cmd_decode
  import keyslot_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic [CMD_W-1:0] cmd_word,
  output load_req_t        req
);
  localparam logic [TID_SLOT_W:0] SLOT_LIM = (TID_SLOT_W + 1)'(NUM_SLOTS);

  logic [OPC_W-1:0]  opc;
  logic [TSEL_W-1:0] tsel;
  logic [TID_W-1:0]  tid;
  logic [ADDR_W-1:0] addr;
  logic              fmt_ok;

  assign opc  = cmd_word[OPC_LSB +: OPC_W];
  assign tsel = cmd_word[TSEL_LSB +: TSEL_W];
  assign tid  = cmd_word[TID_LSB +: TID_W];
  assign addr = cmd_word[ADDR_W-1:0];

  always_comb begin
    fmt_ok = (opc == SET_TABLE_OPC)
          && (tsel == CRYPTO_TSEL)
          && (tid[TID_W-1:TID_SLOT_W] == KEY_TID_TAG)
          && ({1'b0, tid[TID_SLOT_W-1:0]} < SLOT_LIM)
          && (addr[ALIGN_BITS-1:0] == '0);
    req.ok   = fmt_ok;
    req.slot = tid[TID_SLOT_W-1:0];
    req.addr = addr;
  end
endmodule

// File: rtl/keyslot_loader_fsm.sv
module keyslot_loader_fsm
  import keyslot_pkg::*;
#(
  parameter int  SLOT_WORDS = 16,
  parameter int  SEL_W      = 2,
  parameter int  WORD_W     = 32,
  localparam int IDX_W      = $clog2(SLOT_WORDS),
  localparam int CNT_W      = $clog2(SLOT_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  load_req_t         req,
  output logic              busy,
  output logic              cmd_rej,
  output logic              ram_rd_en,
  output logic [RAM_AW-1:0] ram_rd_addr,
  input  logic [WORD_W-1:0] ram_rd_data,
  output logic              wr_en,
  output logic [SEL_W-1:0]  wr_slot,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [WORD_W-1:0] wr_data
);
  typedef enum logic {LD_IDLE, LD_RUN} ld_state_e;

  ld_state_e         state_q;
  logic              rd_en_q;
  logic [RAM_AW-1:0] rd_addr_q;
  logic [CNT_W-1:0]  issued_q;
  logic              dvld_q;
  logic [IDX_W-1:0]  widx_q;
  logic [SEL_W-1:0]  slot_q;
  logic              rej_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= LD_IDLE;
      rd_en_q   <= 1'b0;
      rd_addr_q <= '0;
      issued_q  <= '0;
      dvld_q    <= 1'b0;
      widx_q    <= '0;
      slot_q    <= '0;
      rej_q     <= 1'b0;
    end else begin
      rej_q  <= cmd_valid && (state_q == LD_IDLE) && !req.ok;
      dvld_q <= rd_en_q;
      case (state_q)
        LD_IDLE: begin
          if (cmd_valid && req.ok) begin
            state_q   <= LD_RUN;
            rd_en_q   <= 1'b1;
            rd_addr_q <= req.addr[ADDR_W-1:2];
            issued_q  <= CNT_W'(1);
            widx_q    <= '0;
            slot_q    <= req.slot[SEL_W-1:0];
          end
        end
        LD_RUN: begin
          if (rd_en_q) begin
            if (issued_q == CNT_W'(SLOT_WORDS)) begin
              rd_en_q <= 1'b0;
            end else begin
              rd_addr_q <= rd_addr_q + RAM_AW'(1);
              issued_q  <= issued_q + CNT_W'(1);
            end
          end
          if (dvld_q) begin
            widx_q <= widx_q + IDX_W'(1);
            if (widx_q == IDX_W'(SLOT_WORDS - 1)) state_q <= LD_IDLE;
          end
        end
        default: state_q <= LD_IDLE;
      endcase
    end
  end

  assign busy        = (state_q == LD_RUN);
  assign cmd_rej     = rej_q;
  assign ram_rd_en   = rd_en_q;
  assign ram_rd_addr = rd_addr_q;
  assign wr_en       = dvld_q;
  assign wr_slot     = slot_q;
  assign wr_idx      = widx_q;
  assign wr_data     = ram_rd_data;
endmodule

// File: rtl/keyslot_store.sv
module keyslot_store #(
  parameter int          NUM_SLOTS  = 4,
  parameter int          WORD_W     = 32,
  parameter int          KEY_WORDS  = 8,
  parameter int          IV_WORDS   = 4,
  parameter int          SEL_W      = 2,
  parameter logic [KEY_WORDS*WORD_W-1:0] BOOT_KEY = '0,
  localparam int         SLOT_WORDS = KEY_WORDS + 2 * IV_WORDS,
  localparam int         SLOT_W     = SLOT_WORDS * WORD_W,
  localparam int         IDX_W      = $clog2(SLOT_WORDS),
  localparam int         IV_W       = IV_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_slot,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              upd_en,
  input  logic [SEL_W-1:0]  upd_slot,
  input  logic [IV_W-1:0]   upd_data,
  output logic [SLOT_W-1:0] rec [NUM_SLOTS]
);
  localparam int UPD_LO = KEY_WORDS + IV_WORDS;

  logic [WORD_W-1:0] word_q [NUM_SLOTS][SLOT_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        for (int w = 0; w < SLOT_WORDS; w++) begin
          if (s == 0 && w < KEY_WORDS) word_q[s][w] <= BOOT_KEY[w*WORD_W +: WORD_W];
          else                         word_q[s][w] <= '0;
        end
      end
    end else begin
      if (upd_en) begin
        for (int i = 0; i < IV_WORDS; i++) begin
          word_q[upd_slot][UPD_LO + i] <= upd_data[i*WORD_W +: WORD_W];
        end
      end
      if (wr_en) word_q[wr_slot][wr_idx] <= wr_data;
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      for (int w = 0; w < SLOT_WORDS; w++) begin
        rec[s][w*WORD_W +: WORD_W] = word_q[s][w];
      end
    end
  end
endmodule

// File: rtl/keyslot_readout.sv
module keyslot_readout
  import keyslot_pkg::*;
#(
  parameter int  NUM_SLOTS = 4,
  parameter int  KEY_W     = 256,
  parameter int  IV_W      = 128,
  parameter int  SEL_W     = 2,
  localparam int SLOT_W    = KEY_W + 2 * IV_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SLOT_W-1:0]       rec [NUM_SLOTS],
  input  logic [SLOT_FIELD_W-1:0] act_slot,
  input  logic [LEN_FIELD_W-1:0]  key_len,
  output logic [KEY_W-1:0]        key_out,
  output logic [IV_W-1:0]         iv_orig_out,
  output logic [IV_W-1:0]         iv_upd_out
);
  localparam int KEY_BYTES = KEY_W / 8;
  localparam int NB_W      = $clog2(KEY_BYTES + 1);
  localparam logic [SLOT_FIELD_W-1:0] SLOT_LIM = SLOT_FIELD_W'(NUM_SLOTS);

  logic [NB_W-1:0]   nbytes;
  logic [KEY_W-1:0]  kmask;
  logic [SLOT_W-1:0] chosen;

  assign nbytes = NB_W'(key_len >> 3);

  for (genvar b = 0; b < KEY_BYTES; b++) begin : g_kmask
    assign kmask[b*8 +: 8] = (nbytes > NB_W'(b)) ? 8'hFF : 8'h00;
  end

  always_comb begin
    chosen = '0;
    if (act_slot < SLOT_LIM) chosen = rec[act_slot[SEL_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      key_out     <= '0;
      iv_orig_out <= '0;
      iv_upd_out  <= '0;
    end else begin
      key_out     <= chosen[KEY_W-1:0] & kmask;
      iv_orig_out <= chosen[KEY_W +: IV_W];
      iv_upd_out  <= chosen[KEY_W + IV_W +: IV_W];
    end
  end
endmodule

// File: rtl/keyslot_loader.sv
module keyslot_loader
  import keyslot_pkg::*;
#(
  parameter int  NUM_SLOTS    = 4,
  parameter int  WORD_W       = 32,
  parameter int  KEY_WORDS    = 8,
  parameter int  IV_WORDS     = 4,
  parameter int  KEY_MIN_BITS = 128,
  parameter logic [KEY_WORDS*WORD_W-1:0] BOOT_KEY =
    256'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0_00112233_44556677_8899aabb_ccddeeff,
  localparam int KEY_W        = KEY_WORDS * WORD_W,
  localparam int IV_W         = IV_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic              cmd_rej,
  output logic              busy,
  output logic              ram_rd_en,
  output logic [RAM_AW-1:0] ram_rd_addr,
  input  logic [WORD_W-1:0] ram_rd_data,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              ivu_mode,
  input  logic              iv_upd_we,
  input  logic [IV_W-1:0]   iv_upd_data,
  output logic [KEY_W-1:0]  key_out,
  output logic [IV_W-1:0]   iv_orig_out,
  output logic [IV_W-1:0]   iv_upd_out
);
  localparam int SEL_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int SLOT_WORDS = KEY_WORDS + 2 * IV_WORDS;
  localparam int SLOT_W     = SLOT_WORDS * WORD_W;
  localparam int IDX_W      = $clog2(SLOT_WORDS);
  localparam logic [LEN_FIELD_W-1:0]  LEN_MIN  = LEN_FIELD_W'(KEY_MIN_BITS);
  localparam logic [LEN_FIELD_W-1:0]  LEN_MAX  = LEN_FIELD_W'(KEY_W);
  localparam logic [SLOT_FIELD_W-1:0] SLOT_LIM = SLOT_FIELD_W'(NUM_SLOTS);

  load_req_t                req;
  logic                     wr_en;
  logic [SEL_W-1:0]         wr_slot;
  logic [IDX_W-1:0]         wr_idx;
  logic [WORD_W-1:0]        wr_data;
  logic                     upd_en;
  logic [SLOT_W-1:0]        rec [NUM_SLOTS];
  logic [SLOT_FIELD_W-1:0]  act_slot_q;
  logic [LEN_FIELD_W-1:0]   key_len_q;
  logic [LEN_FIELD_W-1:0]   len_in;
  cfg_target_e              cfg_tgt;

  keyslot_cmd_decode #(.NUM_SLOTS(NUM_SLOTS)) u_dec (
    .cmd_word (cmd_word),
    .req      (req)
  );

  keyslot_loader_fsm #(
    .SLOT_WORDS (SLOT_WORDS),
    .SEL_W      (SEL_W),
    .WORD_W     (WORD_W)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .req         (req),
    .busy        (busy),
    .cmd_rej     (cmd_rej),
    .ram_rd_en   (ram_rd_en),
    .ram_rd_addr (ram_rd_addr),
    .ram_rd_data (ram_rd_data),
    .wr_en       (wr_en),
    .wr_slot     (wr_slot),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data)
  );

  // Configuration registers
  assign cfg_tgt = cfg_target_e'(cfg_sel);
  assign len_in  = cfg_wdata[LEN_FIELD_LSB +: LEN_FIELD_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      act_slot_q <= '0;
      key_len_q  <= LEN_MIN;
    end else if (cfg_we) begin
      case (cfg_tgt)
        CFG_SLOT: act_slot_q <= cfg_wdata[SLOT_FIELD_LSB +: SLOT_FIELD_W];
        CFG_LEN:  if (len_in >= LEN_MIN && len_in <= LEN_MAX) key_len_q <= len_in;
        default:  ;
      endcase
    end
  end

  // Core write of the running IV: only in update mode, never during a load
  assign upd_en = ivu_mode && iv_upd_we && !busy && (act_slot_q < SLOT_LIM);

  keyslot_store #(
    .NUM_SLOTS (NUM_SLOTS),
    .WORD_W    (WORD_W),
    .KEY_WORDS (KEY_WORDS),
    .IV_WORDS  (IV_WORDS),
    .SEL_W     (SEL_W),
    .BOOT_KEY  (BOOT_KEY)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_slot  (wr_slot),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .upd_en   (upd_en),
    .upd_slot (act_slot_q[SEL_W-1:0]),
    .upd_data (iv_upd_data),
    .rec      (rec)
  );

  keyslot_readout #(
    .NUM_SLOTS (NUM_SLOTS),
    .KEY_W     (KEY_W),
    .IV_W      (IV_W),
    .SEL_W     (SEL_W)
  ) u_rd (
    .clk         (clk),
    .rst         (rst),
    .rec         (rec),
    .act_slot    (act_slot_q),
    .key_len     (key_len_q),
    .key_out     (key_out),
    .iv_orig_out (iv_orig_out),
    .iv_upd_out  (iv_upd_out)
  );
endmodule

// File: rtl/keyslot_loader_chk.sv
module keyslot_loader_chk
  import keyslot_pkg::*;
#(
  parameter int NUM_SLOTS    = 4,
  parameter int SLOT_WORDS   = 16,
  parameter int KEY_W        = 256,
  parameter int IV_W         = 128,
  parameter int KEY_MIN_BITS = 128
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cmd_valid,
  input logic                    cmd_rej,
  input logic                    busy,
  input logic                    ram_rd_en,
  input logic [RAM_AW-1:0]       ram_rd_addr,
  input logic [SLOT_FIELD_W-1:0] act_slot_q,
  input logic [LEN_FIELD_W-1:0]  key_len_q,
  input logic [KEY_W-1:0]        key_out,
  input logic [IV_W-1:0]         iv_orig_out,
  input logic [IV_W-1:0]         iv_upd_out
);
  localparam int RUN_W = $clog2(SLOT_WORDS + 2) + 1;

  logic [RUN_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst)       run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + RUN_W'(1);
    else           run_cnt <= '0;
  end

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid));

  // R5
  rd_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    ram_rd_en |-> busy);

  // R5
  rd_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_rd_en && $past(ram_rd_en)) |-> (ram_rd_addr == $past(ram_rd_addr) + RAM_AW'(1)));

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_cnt == RUN_W'(SLOT_WORDS + 1)));

  // R3
  rej_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_rej |-> !busy);

  // R7
  bad_slot_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (act_slot_q >= SLOT_FIELD_W'(NUM_SLOTS)) |=>
      (key_out == '0 && iv_orig_out == '0 && iv_upd_out == '0));

  // R8
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    (key_len_q >= LEN_FIELD_W'(KEY_MIN_BITS)) && (key_len_q <= LEN_FIELD_W'(KEY_W)));
endmodule

bind keyslot_loader keyslot_loader_chk #(
  .NUM_SLOTS    (NUM_SLOTS),
  .SLOT_WORDS   (SLOT_WORDS),
  .KEY_W        (KEY_W),
  .IV_W         (IV_W),
  .KEY_MIN_BITS (KEY_MIN_BITS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid   (cmd_valid),
  .cmd_rej     (cmd_rej),
  .busy        (busy),
  .ram_rd_en   (ram_rd_en),
  .ram_rd_addr (ram_rd_addr),
  .act_slot_q  (act_slot_q),
  .key_len_q   (key_len_q),
  .key_out     (key_out),
  .iv_orig_out (iv_orig_out),
  .iv_upd_out  (iv_upd_out)
);

// File: tb/sim_keyslot_loader.sv
module sim_keyslot_loader;
  localparam int CLK_PERIOD = 10;
  localparam logic [255:0] BOOT =
    256'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0_00112233_44556677_8899aabb_ccddeeff;
  localparam int NVEC = 9;
  // {accept expected, command word}
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b1, 32'h57120100},   // slot 1, addr 0x00100
    {1'b1, 32'h5715FFC0},   // slot 2, addr 0x1FFC0 (top of RAM)
    {1'b0, 32'h57160104},   // misaligned address
    {1'b0, 32'h43160200},   // wrong opcode
    {1'b0, 32'h56160200},   // wrong table select
    {1'b0, 32'h57360200},   // wrong table ID tag
    {1'b0, 32'h57180200},   // slot 4 out of range
    {1'b1, 32'h57160200},   // slot 3, addr 0x00200
    {1'b1, 32'h57100400}    // slot 0, addr 0x00400 (replaces boot key)
  };

  logic         clk = 1'b0;
  logic         rst;
  logic         cmd_valid;
  logic [31:0]  cmd_word;
  logic         cmd_rej;
  logic         busy;
  logic         ram_rd_en;
  logic [14:0]  ram_rd_addr;
  logic [31:0]  ram_rd_data;
  logic         cfg_we;
  logic         cfg_sel;
  logic [31:0]  cfg_wdata;
  logic         ivu_mode;
  logic         iv_upd_we;
  logic [127:0] iv_upd_data;
  logic [255:0] key_out;
  logic [127:0] iv_orig_out;
  logic [127:0] iv_upd_out;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyslot_loader u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_rej(cmd_rej), .busy(busy), .ram_rd_en(ram_rd_en),
    .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_rd_data),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ivu_mode(ivu_mode), .iv_upd_we(iv_upd_we), .iv_upd_data(iv_upd_data),
    .key_out(key_out), .iv_orig_out(iv_orig_out), .iv_upd_out(iv_upd_out)
  );

  function automatic logic [31:0] ramf(logic [14:0] wa);
    return (32'(wa) * 32'h9E3779B1) ^ 32'hC3A51F00;
  endfunction

  function automatic logic [511:0] exp_rec(logic [16:0] a);
    logic [511:0] r;
    for (int w = 0; w < 16; w++) r[w*32 +: 32] = ramf(15'(a[16:2] + 15'(w)));
    return r;
  endfunction

  // RAM model: one cycle read latency
  always @(posedge clk) begin
    if (ram_rd_en) ram_rd_data <= ramf(ram_rd_addr);
  end

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [31:0] w);
    @(negedge clk); cmd_valid = 1'b1; cmd_word = w;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sel_slot(input int s);
    cfg_write(1'b0, 32'(s) << 20);
  endtask

  task automatic set_len(input int l);
    cfg_write(1'b1, 32'(l) << 16);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_slot(input int s, input logic [511:0] r, input string req);
    sel_slot(s);
    chk(key_out == r[255:0], req, 512'(key_out), 512'(r[255:0]));
    chk(iv_orig_out == r[383:256], req, 512'(iv_orig_out), 512'(r[383:256]));
    chk(iv_upd_out == r[511:384], req, 512'(iv_upd_out), 512'(r[511:384]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [511:0] rec1;
    logic [127:0] d_iv;
    rst = 1'b1; cmd_valid = 1'b0; cmd_word = '0; cfg_we = 1'b0; cfg_sel = 1'b0;
    cfg_wdata = '0; ivu_mode = 1'b0; iv_upd_we = 1'b0; iv_upd_data = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1: reset state, slot 0, length 128
    chk(!busy && !ram_rd_en, "R1", 512'({busy, ram_rd_en}), 512'(0));
    chk(key_out == {128'h0, BOOT[127:0]}, "R1", 512'(key_out), 512'({128'h0, BOOT[127:0]}));
    chk(iv_orig_out == '0 && iv_upd_out == '0, "R1", 512'({iv_orig_out, iv_upd_out}), 512'(0));
    check_slot(1, 512'h0, "R1");
    set_len(256);
    check_slot(0, {256'h0, BOOT}, "R1");

    // Vector walk: R2 accept, R3 reject, R4 layout, R5 timing, R11 slot 0
    for (int i = 0; i < NVEC; i++) begin
      int bc;
      int rc;
      bc = 0; rc = 0;
      send_cmd(VEC[i][31:0]);
      if (VEC[i][32]) begin
        chk(busy && !cmd_rej, "R2", 512'({busy, cmd_rej}), 512'(2'b10));
        while (busy) begin
          bc++;
          if (ram_rd_en) rc++;
          @(negedge clk);
        end
        chk(bc == 17, "R5", 512'(bc), 512'(17));
        chk(rc == 16, "R5", 512'(rc), 512'(16));
        repeat (2) @(negedge clk);
        check_slot(int'(VEC[i][19:17]), exp_rec(VEC[i][16:0]),
                   (VEC[i][19:17] == 3'd0) ? "R11" : "R4");
      end else begin
        chk(cmd_rej && !busy, "R3", 512'({cmd_rej, busy}), 512'(2'b10));
        @(negedge clk);
        chk(!cmd_rej && !busy && !ram_rd_en, "R3", 512'({cmd_rej, busy, ram_rd_en}), 512'(0));
      end
    end

    // R6: command during a load is ignored
    send_cmd(32'h57120800);
    repeat (2) @(negedge clk);
    send_cmd(32'h57140900);
    chk(!cmd_rej, "R6", 512'(cmd_rej), 512'(0));
    wait_idle();
    rec1 = exp_rec(17'h00800);
    check_slot(1, rec1, "R6");
    check_slot(2, exp_rec(17'h1FFC0), "R6");

    // R7: out-of-range slot index gives zeros
    sel_slot(5);
    chk(key_out == '0 && iv_orig_out == '0 && iv_upd_out == '0, "R7",
        512'(key_out), 512'(0));

    // R10: running IV write gated by update mode
    sel_slot(1);
    d_iv = 128'hA5A5_0001_B6B6_0002_C7C7_0003_D8D8_0004;
    @(negedge clk); iv_upd_we = 1'b1; iv_upd_data = d_iv;
    @(negedge clk); iv_upd_we = 1'b0;
    repeat (2) @(negedge clk);
    chk(iv_upd_out == rec1[511:384], "R10", 512'(iv_upd_out), 512'(rec1[511:384]));
    ivu_mode = 1'b1;
    @(negedge clk); iv_upd_we = 1'b1;
    @(negedge clk); iv_upd_we = 1'b0;
    repeat (2) @(negedge clk);
    chk(iv_upd_out == d_iv, "R10", 512'(iv_upd_out), 512'(d_iv));
    chk(iv_orig_out == rec1[383:256], "R10", 512'(iv_orig_out), 512'(rec1[383:256]));
    ivu_mode = 1'b0;

    // R8: out-of-range lengths ignored; R9: masking of short keys
    set_len(100);
    chk(key_out == rec1[255:0], "R8", 512'(key_out), 512'(rec1[255:0]));
    set_len(300);
    chk(key_out == rec1[255:0], "R8", 512'(key_out), 512'(rec1[255:0]));
    set_len(192);
    chk(key_out == {64'h0, rec1[191:0]}, "R9", 512'(key_out), 512'({64'h0, rec1[191:0]}));
    set_len(128);
    chk(key_out == {128'h0, rec1[127:0]}, "R9", 512'(key_out), 512'({128'h0, rec1[127:0]}));

    // R1: reset restores boot key in slot 0
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(key_out == {128'h0, BOOT[127:0]}, "R1", 512'(key_out), 512'({128'h0, BOOT[127:0]}));

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule